// File: doc/BRIEF.md
# Two-Lane DDR Serial Sample Receiver

This block takes 12-bit converter samples that arrive as two serial lanes. The lanes toggle on both edges of a source-synchronous bit clock. The bit clock runs at three times the sample rate, so each lane delivers six bits per sample over three bit-clock periods. A separate frame signal runs at the sample rate and rises at the start of each word. The receiver captures both edges of every lane and regroups the half-bits into rising/falling pairs. It uses the frame signal to find the first pair of each word and rebuilds the 12-bit value from the interleaved lanes. Each finished word is presented in the bit-clock domain with a one-cycle valid strobe.

The bits on the wire are twos complement. A format control selects either that coding or offset binary on the output, and offset binary differs only in an inverted MSB. The control is sampled once per word, so one word never mixes the two codings. The output is a plain valid strobe with no ready input. A converter stream cannot be paused, so there is no back-pressure: the consumer must take every word in the cycle it is flagged. A new word can follow every three bit-clock cycles.

Top module: `ddr_adc_rx`

## Requirements
- R1: While `rst_n` is low, `smp_valid` is 0 and `smp_word` is 0.
- R2: The bits of a sample go out MSB first. Lane 0 (`lane_d[0]`) carries word bits 11, 9, 7, 5, 3, 1 in that time order, and lane 1 (`lane_d[1]`) carries bits 10, 8, 6, 4, 2, 0. Within each bit-clock period, the bit captured at the rising edge comes earlier in the word than the bit captured at the falling edge.
- R3: The first pair of a word is the bit-clock period whose rising edge is the first to see `frame_mark` high after an edge that saw it low. Bits 11 and 10 come at that rising edge.
- R4: `smp_valid` is high for exactly one cycle per word. It follows the fourth rising edge after the word's first rising edge, and `smp_word` changes in that same cycle.
- R5: After reset, `smp_valid` stays low until a frame marker has been recognised. The first word it reports is the first complete word that starts at such a marker.
- R6: With `fmt_offset` = 0 the word is passed through in twos complement. With `fmt_offset` = 1 the MSB is inverted, giving offset binary: 0x000 becomes 0x800, 0x800 becomes 0x000, and 0x7FF becomes 0xFFF.
- R7: `fmt_offset` is sampled at the rising edge where a word's assembly begins, which is the edge one period after its first rising edge. A change after that edge applies from the next word on.
- R8: A frame marker that arrives before the current word has all three pairs drops the partial word, which gets no valid strobe. Assembly restarts at the new marker.
- R9: `smp_word` holds its value in every cycle in which `smp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Source-synchronous bit clock; both edges carry lane data |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_mark | input | 1 | Frame signal at the sample rate, high at the start of each word |
| lane_d | input | LANES (2) | Serial lane bits; index 0 carries odd word bits, index 1 even |
| fmt_offset | input | 1 | 0: twos complement output, 1: offset binary output |
| smp_word | output | SAMPLE_W (12) | Rebuilt sample |
| smp_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
A pair counter that loses its place shows up at the ports within one frame. The valid strobes come at the wrong spacing or stop, and every word after that is a rotated mix of two neighbouring samples. A swapped lane or edge order appears at once in the first word as exchanged adjacent bits, and the vectors with uneven lane content expose it. If the format register is updated outside the word boundary, a word whose control changes partway through comes out in the wrong coding. If the lock flag is mishandled, strobes appear on a stream that has no frame marker, or a truncated word gets reported.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;

  localparam int DEF_SAMPLE_W = 12;
  localparam int DEF_LANES    = 2;

  // Word bit index of half-bit slot t (0 = earliest) on lane l.
  function automatic int slot_to_pos(int width, int lanes, int t, int l);
    return width - 1 - (t * lanes + l);
  endfunction

endpackage

// File: rtl/adc_rx_lane_ddr.sv
module adc_rx_lane_ddr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       d,
  output logic [1:0] pair_q   // [0] rising-edge bit, [1] falling-edge bit
);

  logic rise_q;
  logic fall_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      pair_q <= 2'b00;
    end else begin
      rise_q <= d;
      pair_q <= {fall_q, rise_q};
    end
  end

endmodule

// File: rtl/adc_rx_frame_track.sv
module adc_rx_frame_track #(
  parameter int PAIRS   = 3,
  parameter int PHASE_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_mark,
  output logic locked,
  output logic last_pair,
  output logic word_start
);

  logic [1:0]         mark_hist;
  logic               mark_edge;
  logic [PHASE_W-1:0] phase;
  logic               wrap;

  assign mark_edge  = mark_hist[0] & ~mark_hist[1];
  assign wrap       = (phase == PHASE_W'(PAIRS - 1));
  assign last_pair  = wrap & locked;
  assign word_start = mark_edge | wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark_hist <= 2'b00;
      phase     <= '0;
      locked    <= 1'b0;
    end else begin
      mark_hist <= {mark_hist[0], frame_mark};
      if (mark_edge) begin
        phase  <= '0;
        locked <= 1'b1;
      end else if (wrap) begin
        phase  <= '0;
      end else begin
        phase  <= phase + 1'b1;
      end
    end
  end

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    mark_edge |=> !last_pair) else $error("marker did not restart word");  // R8

endmodule

// File: rtl/adc_rx_word_build.sv
module adc_rx_word_build
  import adc_rx_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LANES    = 2,
  parameter int PAIRS    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0][1:0]       pair_bits,
  input  logic                        last_pair,
  input  logic                        word_start,
  input  logic                        fmt_offset,
  output logic [SAMPLE_W-1:0]         smp_word,
  output logic                        smp_valid
);

  localparam logic [SAMPLE_W-1:0] MSB_MASK = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [PAIRS-2:0][LANES-1:0][1:0] hist;
  logic [PAIRS-1:0][LANES-1:0][1:0] all_pairs;
  logic [SAMPLE_W-1:0]              raw;
  logic                             fmt_act;

  assign all_pairs = {pair_bits, hist};

  always_comb begin
    raw = '0;
    for (int p = 0; p < PAIRS; p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int l = 0; l < LANES; l++) begin
          raw[slot_to_pos(SAMPLE_W, LANES, 2 * p + s, l)] = all_pairs[p][l][s];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist      <= '0;
      fmt_act   <= 1'b0;
      smp_word  <= '0;
      smp_valid <= 1'b0;
    end else begin
      for (int i = 0; i < PAIRS - 2; i++) hist[i] <= hist[i+1];
      hist[PAIRS-2] <= pair_bits;
      if (word_start) fmt_act <= fmt_offset;
      smp_valid <= last_pair;
      if (last_pair) smp_word <= fmt_act ? (raw ^ MSB_MASK) : raw;
    end
  end

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_word)) else $error("word changed without strobe");  // R9

endmodule

// File: rtl/ddr_adc_rx.sv
module ddr_adc_rx
  import adc_rx_pkg::*;
#(
  parameter int SAMPLE_W = DEF_SAMPLE_W,
  parameter int LANES    = DEF_LANES
) (
  input  logic                bit_clk,
  input  logic                rst_n,
  input  logic                frame_mark,
  input  logic [LANES-1:0]    lane_d,
  input  logic                fmt_offset,
  output logic [SAMPLE_W-1:0] smp_word,
  output logic                smp_valid
);

  localparam int BITS_PER_LANE = SAMPLE_W / LANES;
  localparam int PAIRS         = BITS_PER_LANE / 2;
  localparam int PHASE_W       = (PAIRS > 2) ? $clog2(PAIRS) : 1;

  logic [LANES-1:0][1:0] pair_bits;
  logic                  locked;
  logic                  last_pair;
  logic                  word_start;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      adc_rx_lane_ddr u_lane (
        .clk    (bit_clk),
        .rst_n  (rst_n),
        .d      (lane_d[g]),
        .pair_q (pair_bits[g])
      );
    end
  endgenerate

  adc_rx_frame_track #(.PAIRS(PAIRS), .PHASE_W(PHASE_W)) u_track (
    .clk        (bit_clk),
    .rst_n      (rst_n),
    .frame_mark (frame_mark),
    .locked     (locked),
    .last_pair  (last_pair),
    .word_start (word_start)
  );

  adc_rx_word_build #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .PAIRS(PAIRS)) u_build (
    .clk        (bit_clk),
    .rst_n      (rst_n),
    .pair_bits  (pair_bits),
    .last_pair  (last_pair),
    .word_start (word_start),
    .fmt_offset (fmt_offset),
    .smp_word   (smp_word),
    .smp_valid  (smp_valid)
  );

  AST_VALID_SINGLE: assert property (@(posedge bit_clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid) else $error("strobe longer than one cycle");  // R4
  AST_VALID_SPACING: assert property (@(posedge bit_clk) disable iff (!rst_n)
    smp_valid |-> !$past(smp_valid) && !$past(smp_valid, 2)) else $error("strobes too close");  // R4
  AST_NO_EARLY_VALID: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(locked) |-> !smp_valid) else $error("strobe at lock time");  // R5
  AST_VALID_LOCKED: assert property (@(posedge bit_clk) disable iff (!rst_n)
    smp_valid |-> locked) else $error("strobe without marker");  // R5

endmodule

// File: tb/ddr_adc_rx_tb_top.sv
`timescale 1ns/1ps
module ddr_adc_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_mark = 1'b0;
  logic [1:0]  lane_d = 2'b00;
  logic        fmt_offset = 1'b0;
  logic [11:0] smp_word;
  logic        smp_valid;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [11:0] got [0:63];
  int          got_n = 0;

  // {fmt, raw twos complement on the wire, expected output}
  localparam logic [24:0] VEC [0:11] = '{
    {1'b0, 12'h000, 12'h000},
    {1'b1, 12'h000, 12'h800},
    {1'b0, 12'h800, 12'h800},
    {1'b1, 12'h800, 12'h000},
    {1'b0, 12'h7FF, 12'h7FF},
    {1'b1, 12'h7FF, 12'hFFF},
    {1'b0, 12'hA5C, 12'hA5C},
    {1'b1, 12'h3C6, 12'hBC6},
    {1'b0, 12'h555, 12'h555},
    {1'b1, 12'hAAA, 12'h2AA},
    {1'b0, 12'h001, 12'h001},
    {1'b0, 12'h400, 12'h400}
  };

  always #2.5 clk = ~clk;

  ddr_adc_rx dut_i (
    .bit_clk    (clk),
    .rst_n      (rst_n),
    .frame_mark (frame_mark),
    .lane_d     (lane_d),
    .fmt_offset (fmt_offset),
    .smp_word   (smp_word),
    .smp_valid  (smp_valid)
  );

  always @(negedge clk) begin
    if (smp_valid === 1'b1 && got_n < 64) begin
      got[got_n] = smp_word;
      got_n++;
    end
  end

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_n(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    frame_mark = 1'b0;
    lane_d = 2'b00;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
  endtask

  // Drives npairs bit-clock periods of word w; fmt_b applies after the second rising edge.
  task automatic drive_word(input logic [11:0] w, input logic fmt_a, input logic fmt_b,
                            input int npairs, input logic mark);
    for (int p = 0; p < npairs; p++) begin
      @(negedge clk); #1;
      lane_d = {w[10-4*p], w[11-4*p]};
      frame_mark = mark && (p == 0 || (p == 1 && npairs == 3));
      if (p == 0) fmt_offset = fmt_a;
      @(posedge clk); #1;
      lane_d = {w[8-4*p], w[9-4*p]};
      frame_mark = mark && (p == 0);
      if (p == 1) fmt_offset = fmt_b;
    end
  endtask

  // Returns just after the sampling point of the last driven word's strobe.
  task automatic wait_out();
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
  endtask

  initial begin
    #500000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int base;
    // R1 reset state
    do_reset();
    rst_n = 1'b0;
    @(negedge clk); #1;
    check("R1 word in reset", smp_word, 12'h000);
    check("R1 valid in reset", {11'b0, smp_valid}, 12'h000);
    #1 rst_n = 1'b1;

    // R5 no marker, no strobe
    base = got_n;
    for (int i = 0; i < 4; i++) drive_word(12'hF0F, 1'b0, 1'b0, 3, 1'b0);
    wait_out();
    check_n("R5 strobes without marker", got_n - base, 0);

    // R2 R3 R4 R6 table stream
    do_reset();
    base = got_n;
    for (int i = 0; i < 12; i++) drive_word(VEC[i][23:12], VEC[i][24], VEC[i][24], 3, 1'b1);
    wait_out();
    check_n("R4 R5 strobe count", got_n - base, 12);
    for (int i = 0; i < 12; i++) check("R2 R3 R6 vector", got[base + i], VEC[i][11:0]);
    rst_n = 1'b0;
    #1;
    check("R1 word after reset", smp_word, 12'h000);
    check("R1 valid after reset", {11'b0, smp_valid}, 12'h000);

    // R7 format change partway through a word
    do_reset();
    base = got_n;
    drive_word(12'h123, 1'b0, 1'b1, 3, 1'b1);
    drive_word(12'h123, 1'b1, 1'b1, 3, 1'b1);
    wait_out();
    check_n("R7 strobe count", got_n - base, 2);
    check("R7 late change ignored", got[base], 12'h123);
    check("R7 next word offset", got[base + 1], 12'h923);
    check("R9 word held", smp_word, 12'h923);

    // R8 early marker drops the partial word
    do_reset();
    base = got_n;
    drive_word(12'hFFF, 1'b0, 1'b0, 2, 1'b1);
    drive_word(12'h456, 1'b0, 1'b0, 3, 1'b1);
    wait_out();
    check_n("R8 strobe count", got_n - base, 1);
    check("R8 realigned word", got[base], 12'h456);
    rst_n = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule